// File: doc/BRIEF.md
# Destination Hazard Scoreboard

This block records, in program order, the destination register of every instruction that has been dispatched past decode in an in-order pipeline and has not yet committed. Decode presents its two source operands on two search ports and learns in the same cycle whether either operand waits for an older, still uncommitted write. When a hazard is reported, decode holds the instruction back.

Entries live in a circular queue whose depth is a parameter. An instruction that writes no register still takes a slot, marked as having no destination, so that every commit removes exactly one entry. A remove applied in a cycle is seen by that cycle's searches. A dependent instruction can therefore leave decode in the same cycle in which its producer commits. An insert made in a cycle becomes visible to searches from the next cycle on.

Top module: `raw_scoreboard`

## Requirements
- R1: While rst_ni is low the queue is emptied. After reset empty_o is 1, full_o is 0, and both hazard outputs are 0 for any source.
- R2: A cycle with ins_valid_i high, when accepted, appends one entry holding ins_dst_vld_i and ins_dst_idx_i at the young end. An entry with ins_dst_vld_i low still occupies a slot but never matches a search.
- R3: An insert is dropped when the queue holds DEPTH entries, unless a remove takes effect in the same cycle. In that case both happen and the count is unchanged.
- R4: rem_valid_i deletes the oldest entry. On an empty queue it is ignored, and a same-cycle insert is still accepted.
- R5: hazard_a_o is 1 only when src_a_vld_i is 1 and some visible entry has its valid flag set and an index equal to src_a_idx_i.
- R6: hazard_b_o is computed from src_b_vld_i and src_b_idx_i by the same rule, independently of port A, in the same cycle.
- R7: An entry being removed in the current cycle is excluded from that cycle's searches.
- R8: An entry inserted in the current cycle is not seen by searches until the following cycle.
- R9: When several entries hold the same index, a search for it keeps reporting a hazard until the last of them is removed.
- R10: full_o is 1 exactly when DEPTH entries are held. empty_o is 1 exactly when none are held.
- R11: Searches are combinational and change no state. A cycle with only search activity leaves the contents, full_o and empty_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | 1 | Insert request at dispatch |
| ins_dst_vld_i | input | 1 | Inserted instruction writes a register |
| ins_dst_idx_i | input | IDX_W | Destination register index |
| rem_valid_i | input | 1 | Remove oldest entry at commit |
| src_a_vld_i | input | 1 | Source A is a real register operand |
| src_a_idx_i | input | IDX_W | Source A register index |
| src_b_vld_i | input | 1 | Source B is a real register operand |
| src_b_idx_i | input | IDX_W | Source B register index |
| hazard_a_o | output | 1 | Source A waits on an uncommitted write |
| hazard_b_o | output | 1 | Source B waits on an uncommitted write |
| full_o | output | 1 | Queue holds DEPTH entries |
| empty_o | output | 1 | Queue holds no entries |

## Verification
Commit and search can fall in the same cycle, and so can commit and dispatch. The bench provokes the first case by searching for the oldest entry's index while asserting rem_valid_i, on a queue holding one entry and on a queue holding several. A hazard is expected only from a younger matching entry. It provokes the second case by inserting into a full queue while removing, and by inserting and searching the same index on an empty queue. The behavioural queue model judges each cycle: it applies the remove first, evaluates the searches, and then appends the insert.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b10,
    OP_POP  = 2'b01,
    OP_SWAP = 2'b11
  } q_op_e;
endpackage

// File: rtl/sb_queue_ctrl.sv
module sb_queue_ctrl #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned PTR_W = 2,
  parameter int unsigned CNT_W = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ins_req_i,
  input  logic                 rem_req_i,
  output logic                 push_o,
  output logic                 pop_o,
  output logic [PTR_W-1:0]     wr_ptr_o,
  output logic [PTR_W-1:0]     rd_ptr_o,
  output logic [CNT_W-1:0]     count_o,
  output logic                 full_o,
  output logic                 empty_o,
  output logic [DEPTH-1:0]     visible_o
);
  import sb_pkg::*;

  localparam int unsigned OFF_W = CNT_W + 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  q_op_e            op;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign pop_o   = rem_req_i & ~empty_o;
  // a same-cycle pop frees the slot the push needs
  assign push_o  = ins_req_i & (~full_o | pop_o);
  assign op      = q_op_e'({push_o, pop_o});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      unique case (op)
        OP_PUSH: begin
          wr_q  <= ptr_inc(wr_q);
          cnt_q <= cnt_q + CNT_W'(1);
        end
        OP_POP: begin
          rd_q  <= ptr_inc(rd_q);
          cnt_q <= cnt_q - CNT_W'(1);
        end
        OP_SWAP: begin
          wr_q <= ptr_inc(wr_q);
          rd_q <= ptr_inc(rd_q);
        end
        default: ;
      endcase
    end
  end

  // per-slot age offset from the head; the head is hidden while it is being popped
  for (genvar i = 0; i < DEPTH; i++) begin : g_vis
    logic [OFF_W-1:0] off;
    always_comb begin
      if (OFF_W'(i) >= OFF_W'(rd_q)) off = OFF_W'(i) - OFF_W'(rd_q);
      else                           off = OFF_W'(i) + OFF_W'(DEPTH) - OFF_W'(rd_q);
    end
    assign visible_o[i] = (off < OFF_W'(cnt_q)) && !(pop_o && (off == '0));
  end

  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;
  assign count_o  = cnt_q;

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && ins_req_i && !rem_req_i |=> full_o && $stable(wr_q));

  assert_empty_pop_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && rem_req_i && !ins_req_i |=> empty_o && $stable(rd_q));

  assert_push_fills_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o && !pop_o |=> !empty_o);

  assert_swap_keeps_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o && pop_o |=> $stable(cnt_q));
endmodule

// File: rtl/sb_entry_store.sv
module sb_entry_store #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned IDX_W = 5,
  parameter int unsigned PTR_W = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            push_i,
  input  logic [PTR_W-1:0]                wr_ptr_i,
  input  logic                            dst_vld_i,
  input  logic [IDX_W-1:0]                dst_idx_i,
  output logic [DEPTH-1:0]                ent_vld_o,
  output logic [DEPTH-1:0][IDX_W-1:0]     ent_idx_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic wr_en;
    assign wr_en = push_i && (wr_ptr_i == PTR_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_vld_o[i] <= 1'b0;
        ent_idx_o[i] <= '0;
      end else if (wr_en) begin
        ent_vld_o[i] <= dst_vld_i;
        ent_idx_o[i] <= dst_idx_i;
      end
    end
  end
endmodule

// File: rtl/sb_search_port.sv
module sb_search_port #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned IDX_W = 5
) (
  input  logic                        src_vld_i,
  input  logic [IDX_W-1:0]            src_idx_i,
  input  logic [DEPTH-1:0]            visible_i,
  input  logic [DEPTH-1:0]            ent_vld_i,
  input  logic [DEPTH-1:0][IDX_W-1:0] ent_idx_i,
  output logic                        hit_o
);
  logic [DEPTH-1:0] match;
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = visible_i[i] && ent_vld_i[i] && (ent_idx_i[i] == src_idx_i);
  end
  assign hit_o = src_vld_i && (|match);
endmodule

// File: rtl/raw_scoreboard.sv
module raw_scoreboard #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ins_valid_i,
  input  logic             ins_dst_vld_i,
  input  logic [IDX_W-1:0] ins_dst_idx_i,
  input  logic             rem_valid_i,
  input  logic             src_a_vld_i,
  input  logic [IDX_W-1:0] src_a_idx_i,
  input  logic             src_b_vld_i,
  input  logic [IDX_W-1:0] src_b_idx_i,
  output logic             hazard_a_o,
  output logic             hazard_b_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned N_SRC = 2;

  logic                        push, pop;
  logic [PTR_W-1:0]            wr_ptr, rd_ptr;
  logic [CNT_W-1:0]            count;
  logic [DEPTH-1:0]            visible;
  logic [DEPTH-1:0]            ent_vld;
  logic [DEPTH-1:0][IDX_W-1:0] ent_idx;

  logic [N_SRC-1:0]            s_vld, s_hit;
  logic [N_SRC-1:0][IDX_W-1:0] s_idx;

  sb_queue_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ins_req_i (ins_valid_i),
    .rem_req_i (rem_valid_i),
    .push_o    (push),
    .pop_o     (pop),
    .wr_ptr_o  (wr_ptr),
    .rd_ptr_o  (rd_ptr),
    .count_o   (count),
    .full_o    (full_o),
    .empty_o   (empty_o),
    .visible_o (visible)
  );

  sb_entry_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PTR_W(PTR_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (push),
    .wr_ptr_i  (wr_ptr),
    .dst_vld_i (ins_dst_vld_i),
    .dst_idx_i (ins_dst_idx_i),
    .ent_vld_o (ent_vld),
    .ent_idx_o (ent_idx)
  );

  assign s_vld = {src_b_vld_i, src_a_vld_i};
  assign s_idx = {src_b_idx_i, src_a_idx_i};

  for (genvar p = 0; p < N_SRC; p++) begin : g_port
    sb_search_port #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_srch (
      .src_vld_i (s_vld[p]),
      .src_idx_i (s_idx[p]),
      .visible_i (visible),
      .ent_vld_i (ent_vld),
      .ent_idx_i (ent_idx),
      .hit_o     (s_hit[p])
    );
  end

  assign hazard_a_o = s_hit[0];
  assign hazard_b_o = s_hit[1];

  assert_empty_no_hazard_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !hazard_a_o && !hazard_b_o);

  assert_removed_not_seen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count == CNT_W'(1)) && rem_valid_i |-> !hazard_a_o && !hazard_b_o);

  assert_search_pure_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ins_valid_i && !rem_valid_i |=> $stable(count) && $stable(rd_ptr) && $stable(wr_ptr));

  assert_unused_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_a_vld_i |-> !hazard_a_o);

  assert_unused_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_b_vld_i |-> !hazard_b_o);
endmodule

// File: tb/raw_scoreboard_tb.sv
module raw_scoreboard_tb;
  localparam int DEPTH = 4;
  localparam int IDX_W = 5;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             ins_valid_i = 1'b0, ins_dst_vld_i = 1'b0, rem_valid_i = 1'b0;
  logic [IDX_W-1:0] ins_dst_idx_i = '0, src_a_idx_i = '0, src_b_idx_i = '0;
  logic             src_a_vld_i = 1'b0, src_b_vld_i = 1'b0;
  logic             hazard_a_o, hazard_b_o, full_o, empty_o;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R1";

  // model entry: bit IDX_W = destination valid
  logic [IDX_W:0] mq[$];

  always #2 clk_i = ~clk_i;

  raw_scoreboard #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_dut (
    .clk_i, .rst_ni, .ins_valid_i, .ins_dst_vld_i, .ins_dst_idx_i, .rem_valid_i,
    .src_a_vld_i, .src_a_idx_i, .src_b_vld_i, .src_b_idx_i,
    .hazard_a_o, .hazard_b_o, .full_o, .empty_o
  );

  task automatic chk(input string what, input logic got, input logic exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %0b expected %0b", cur_req, what, got, exp);
    end
  endtask

  function automatic logic model_hit(input logic v, input logic [IDX_W-1:0] idx, input logic rem);
    int first = (rem && mq.size() > 0) ? 1 : 0;
    if (!v) return 1'b0;
    for (int k = first; k < mq.size(); k++)
      if (mq[k][IDX_W] && mq[k][IDX_W-1:0] == idx) return 1'b1;
    return 1'b0;
  endfunction

  task automatic step(input logic ins, input logic dv, input logic [IDX_W-1:0] di,
                      input logic rem, input logic av, input logic [IDX_W-1:0] ai,
                      input logic bv, input logic [IDX_W-1:0] bi);
    logic do_pop, do_push;
    ins_valid_i = ins; ins_dst_vld_i = dv; ins_dst_idx_i = di; rem_valid_i = rem;
    src_a_vld_i = av; src_a_idx_i = ai; src_b_vld_i = bv; src_b_idx_i = bi;
    #1;
    chk("hazard_a", hazard_a_o, model_hit(av, ai, rem));
    chk("hazard_b", hazard_b_o, model_hit(bv, bi, rem));
    chk("full", full_o, mq.size() == DEPTH);
    chk("empty", empty_o, mq.size() == 0);
    do_pop  = rem && mq.size() > 0;
    do_push = ins && (mq.size() < DEPTH || do_pop);
    @(posedge clk_i);
    if (do_pop) void'(mq.pop_front());
    if (do_push) mq.push_back({dv, di});
    @(negedge clk_i);
  endtask

  task automatic idle_search(input logic [IDX_W-1:0] ai, input logic [IDX_W-1:0] bi);
    step(0, 0, 0, 0, 1, ai, 1, bi);
  endtask

  initial begin
    #400000;
    compared++;
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: outputs while in reset and right after
    src_a_vld_i = 1; src_a_idx_i = 5'd3; src_b_vld_i = 1; src_b_idx_i = 5'd0;
    #1;
    chk("empty in reset", empty_o, 1'b1);
    chk("full in reset", full_o, 1'b0);
    chk("hazard_a in reset", hazard_a_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    cur_req = "R1";
    idle_search(5'd3, 5'd0);

    // R2: fill with a mix including a no-destination entry; R10 full flag
    cur_req = "R2";
    step(1, 1, 5'd3, 0, 1, 5'd3, 0, 0);   // same-cycle insert not visible
    step(1, 0, 5'd7, 0, 1, 5'd3, 1, 5'd7);
    step(1, 1, 5'd9, 0, 1, 5'd7, 1, 5'd9);
    cur_req = "R10";
    step(1, 1, 5'd12, 0, 1, 5'd12, 1, 5'd9);
    idle_search(5'd7, 5'd12);             // invalid entry 7 never matches

    // R3: refused insert when full, then swap insert
    cur_req = "R3";
    step(1, 1, 5'd20, 0, 1, 5'd20, 0, 0);
    idle_search(5'd20, 5'd3);
    step(1, 1, 5'd21, 1, 1, 5'd3, 1, 5'd21);
    idle_search(5'd21, 5'd3);

    // R7: remove head while searching its index
    cur_req = "R7";
    step(0, 0, 0, 1, 1, 5'd7, 1, 5'd9);
    step(0, 0, 0, 1, 1, 5'd9, 1, 5'd12);
    step(0, 0, 0, 1, 1, 5'd12, 1, 5'd21);
    step(0, 0, 0, 1, 1, 5'd21, 1, 5'd21); // last entry removed -> no hazard

    // R4: removes on empty are ignored; insert alongside still accepted
    cur_req = "R4";
    step(0, 0, 0, 1, 1, 5'd21, 0, 0);
    step(1, 1, 5'd4, 1, 1, 5'd4, 0, 0);
    idle_search(5'd4, 5'd1);

    // R8: insert and search same index on the same cycle
    cur_req = "R8";
    step(1, 1, 5'd5, 0, 1, 5'd5, 1, 5'd4);
    idle_search(5'd5, 5'd4);

    // R9: duplicate destinations
    cur_req = "R9";
    step(1, 1, 5'd4, 0, 1, 5'd4, 1, 5'd5);
    step(0, 0, 0, 1, 1, 5'd4, 1, 5'd5);
    step(0, 0, 0, 1, 1, 5'd4, 1, 5'd5);
    step(0, 0, 0, 1, 1, 5'd4, 1, 5'd5);

    // R5 / R6: invalid sources with matching index, independent ports
    cur_req = "R5";
    step(1, 1, 5'd2, 0, 0, 5'd2, 0, 5'd2);
    step(0, 0, 0, 0, 0, 5'd2, 1, 5'd2);
    cur_req = "R6";
    step(0, 0, 0, 0, 1, 5'd2, 0, 5'd2);
    step(0, 0, 0, 0, 1, 5'd0, 1, 5'd2);

    // R11: search-only cycles leave everything as it was
    cur_req = "R11";
    for (int k = 0; k < 6; k++) idle_search(IDX_W'(k), IDX_W'(k + 1));
    idle_search(5'd2, 5'd2);

    // random mix, tagged by the main search rule
    cur_req = "R5";
    for (int k = 0; k < 400; k++)
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0), IDX_W'($urandom_range(0, 3)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), IDX_W'($urandom_range(0, 3)),
           1'($urandom_range(0, 1)), IDX_W'($urandom_range(0, 3)));

    // R1: reset mid-run empties the queue
    cur_req = "R1";
    rst_ni = 1'b0;
    mq.delete();
    #1;
    chk("empty after reset", empty_o, 1'b1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle_search(5'd0, 5'd1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule